// File: doc/BRIEF.md
# Frame-Sync Rate Select Decoder

This block sits at the front of a voice encoder's transmit side and runs on the transmit bit clock. Once per 125 µs frame (one 8 kHz sample period), the transmit frame-sync enable is asserted for a number of bit clocks. That number tells the encoder which coding rate to use for a later sample. A pulse 2 clocks wide selects 16 kbps ADPCM, 3 clocks selects 24 kbps, 4 clocks selects 32 kbps, and 8 clocks selects 64 kbps PCM. The block counts the width of each pulse and classifies it when the enable falls.

The resulting two-bit rate request passes through a short request pipeline. By default the request reaches the encoder two frames after the frame in which it was measured. With the long-delay select raised, it arrives six frames later, so that transmit and receive can share clocks and stay aligned to a six-frame signalling cycle. Only the small rate request travels through the pipeline. Sample data never enters it.

A pulse of any other width is flagged as invalid, and the last good request is repeated in its place. After reset the pipeline holds the 64 kbps code, and the valid strobe stays quiet until real requests reach the selected output tap.

Top module: `fsrate_decoder`

## Requirements
- R1: A frame-sync pulse that is high for 2, 3, 4 or 8 sampled bit clocks produces the rate codes 0 (16 kbps), 1 (24 kbps), 2 (32 kbps) or 3 (64 kbps) respectively.
- R2: A pulse of any other width sets `lenBad` and pushes the most recent valid code instead, or code 3 if no valid pulse has been seen since reset. A valid width clears `lenBad`.
- R3: With `longDelay` low, the `rateCode` presented after the k-th frame event is the code pushed at event k-2, or 3 when k is 2 or less.
- R4: With `longDelay` high, the `rateCode` presented after the k-th frame event is the code pushed at event k-6, or 3 when k is 6 or less.
- R5: `rateValid` pulses high for exactly one clock after the k-th frame event when k exceeds the selected delay (2 or 6), and is low otherwise.
- R6: While `rst` is high and in the first cycle after it, `rateCode` is 3, and `rateValid` and `lenBad` are 0.
- R7: A frame event is the clock edge at which the enable is first sampled low after being high. `rateCode` and `lenBad` change only at frame events and hold their values through the low gap between pulses.
- R8: The width counter saturates at 15 and never wraps, so any pulse 15 clocks or longer, including 18 and 19, is reported as invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst | input | 1 | Synchronous reset, active high |
| syncEn | input | 1 | Transmit frame-sync enable; its width encodes the rate |
| longDelay | input | 1 | 0: two-frame request delay, 1: six-frame request delay |
| rateCode | output | 2 | Delayed rate request (0=16k, 1=24k, 2=32k, 3=64k) |
| rateValid | output | 1 | One-clock strobe per frame once the pipeline has filled |
| lenBad | output | 1 | Last measured width matched no rate |

## Verification
The bench uses the default parameters: widths 2, 3, 4 and 8, delay taps at 2 and 6, and a 4-bit width counter. These values keep the counter small enough that widths 1 to 19 cover every valid code, every invalid class, saturation at 15, and the wrap-around case at 18 and 19, where a non-saturating counter would alias to a valid code. Both delay taps are swept from reset, which brings the pipeline fill boundary for each mode within reach.

// File: rtl/fsrate_pkg.sv
package fsrate_pkg;

  typedef enum logic [1:0] {
    RATE_16K = 2'd0,
    RATE_24K = 2'd1,
    RATE_32K = 2'd2,
    RATE_64K = 2'd3
  } rate_e;

  // control -> datapath strobes
  typedef struct packed {
    logic frameTick;   // enable fell this cycle
    logic emitValid;   // pipeline filled for selected tap
    logic useLong;     // select the long tap
  } ctl_strobe_t;

endpackage

// File: rtl/fsrate_ctl.sv
module fsrate_ctl
  import fsrate_pkg::*;
#(
  parameter int LEN_W       = 4,
  parameter int SHORT_DELAY = 2,
  parameter int LONG_DELAY  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             syncEn,
  input  logic             longDelay,
  output ctl_strobe_t      strobe,
  output logic [LEN_W-1:0] measLen
);

  localparam int FILL_W = $clog2(LONG_DELAY + 1);
  localparam logic [LEN_W-1:0]  LEN_MAX   = '1;
  localparam logic [FILL_W-1:0] FILL_LONG = FILL_W'(LONG_DELAY);
  localparam logic [FILL_W-1:0] FILL_SHRT = FILL_W'(SHORT_DELAY);

  logic              prevEn;
  logic [LEN_W-1:0]  runLen;
  logic [FILL_W-1:0] fillCnt;
  logic [FILL_W-1:0] needFill;
  logic              fallNow;

  assign fallNow  = prevEn & ~syncEn;
  assign needFill = longDelay ? FILL_LONG : FILL_SHRT;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevEn <= 1'b0;
      runLen <= '0;
    end else begin
      prevEn <= syncEn;
      if (!syncEn)
        runLen <= '0;
      else if (runLen != LEN_MAX)
        runLen <= runLen + 1'b1;
    end
  end

  // count frames since reset, saturating at the long tap
  always_ff @(posedge clk) begin
    if (rst)
      fillCnt <= '0;
    else if (fallNow && fillCnt != FILL_LONG)
      fillCnt <= fillCnt + 1'b1;
  end

  always_comb begin
    strobe.frameTick = fallNow;
    strobe.emitValid = fallNow && (fillCnt >= needFill);
    strobe.useLong   = longDelay;
    measLen          = runLen;
  end

  // a fall always follows at least one high sample (R1)
  p_len_nonzero_r1: assert property (@(posedge clk) disable iff (rst)
    strobe.frameTick |-> (measLen != '0));

  // two frame events are never adjacent (R7)
  p_tick_spacing_r7: assert property (@(posedge clk) disable iff (rst)
    strobe.frameTick |=> !strobe.frameTick);

  // counter never goes backwards except on reset (R8)
  p_len_no_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(syncEn) && syncEn && $past(runLen) == LEN_MAX) |-> (runLen == LEN_MAX));

endmodule

// File: rtl/fsrate_dp.sv
module fsrate_dp
  import fsrate_pkg::*;
#(
  parameter int LEN_W       = 4,
  parameter int LEN_16K     = 2,
  parameter int LEN_24K     = 3,
  parameter int LEN_32K     = 4,
  parameter int LEN_64K     = 8,
  parameter int SHORT_DELAY = 2,
  parameter int LONG_DELAY  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  ctl_strobe_t      strobe,
  input  logic [LEN_W-1:0] measLen,
  output rate_e            rateCode,
  output logic             rateValid,
  output logic             lenBad
);

  localparam int STAGES = LONG_DELAY;

  logic  lenHit;
  rate_e lenCode;
  rate_e lastGood;
  rate_e pushCode;
  rate_e pipe [STAGES];
  rate_e tapSel;

  always_comb begin
    lenHit  = 1'b1;
    lenCode = RATE_64K;
    if (measLen == LEN_W'(LEN_16K))      lenCode = RATE_16K;
    else if (measLen == LEN_W'(LEN_24K)) lenCode = RATE_24K;
    else if (measLen == LEN_W'(LEN_32K)) lenCode = RATE_32K;
    else if (measLen == LEN_W'(LEN_64K)) lenCode = RATE_64K;
    else                                 lenHit  = 1'b0;
  end

  assign pushCode = lenHit ? lenCode : lastGood;

  always_ff @(posedge clk) begin
    if (rst)
      lastGood <= RATE_64K;
    else if (strobe.frameTick && lenHit)
      lastGood <= lenCode;
  end

  // request pipeline, advanced once per frame
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst)                   pipe[0] <= RATE_64K;
        else if (strobe.frameTick) pipe[0] <= pushCode;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst)                   pipe[i] <= RATE_64K;
        else if (strobe.frameTick) pipe[i] <= pipe[i-1];
      end
    end
  end

  // tap read before the shift: stage d-1 holds the request from d frames back
  assign tapSel = strobe.useLong ? pipe[LONG_DELAY-1] : pipe[SHORT_DELAY-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      rateCode  <= RATE_64K;
      lenBad    <= 1'b0;
      rateValid <= 1'b0;
    end else begin
      rateValid <= strobe.emitValid;
      if (strobe.frameTick) begin
        rateCode <= tapSel;
        lenBad   <= ~lenHit;
      end
    end
  end

  // reset leaves idle outputs (R6)
  p_reset_idle_r6: assert property (@(posedge clk)
    $past(rst) |-> (rateCode == RATE_64K && !rateValid && !lenBad));

  // strobe lasts one clock (R5)
  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    rateValid |=> !rateValid);

  // valid only follows a frame event (R5)
  p_valid_after_tick_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(rateValid) |-> $past(strobe.frameTick));

  // outputs hold between frame events (R7)
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(strobe.frameTick) |-> ($stable(rateCode) && $stable(lenBad)));

  // invalid flag rises only on a measured frame (R2)
  p_bad_on_frame_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(lenBad) |-> $past(strobe.frameTick));

endmodule

// File: rtl/fsrate_decoder.sv
module fsrate_decoder
  import fsrate_pkg::*;
#(
  parameter int LEN_W       = 4,
  parameter int LEN_16K     = 2,
  parameter int LEN_24K     = 3,
  parameter int LEN_32K     = 4,
  parameter int LEN_64K     = 8,
  parameter int SHORT_DELAY = 2,
  parameter int LONG_DELAY  = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       syncEn,
  input  logic       longDelay,
  output logic [1:0] rateCode,
  output logic       rateValid,
  output logic       lenBad
);

  ctl_strobe_t      strobe;
  logic [LEN_W-1:0] measLen;
  rate_e            codeOut;

  fsrate_ctl #(
    .LEN_W      (LEN_W),
    .SHORT_DELAY(SHORT_DELAY),
    .LONG_DELAY (LONG_DELAY)
  ) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .syncEn   (syncEn),
    .longDelay(longDelay),
    .strobe   (strobe),
    .measLen  (measLen)
  );

  fsrate_dp #(
    .LEN_W      (LEN_W),
    .LEN_16K    (LEN_16K),
    .LEN_24K    (LEN_24K),
    .LEN_32K    (LEN_32K),
    .LEN_64K    (LEN_64K),
    .SHORT_DELAY(SHORT_DELAY),
    .LONG_DELAY (LONG_DELAY)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .measLen  (measLen),
    .rateCode (codeOut),
    .rateValid(rateValid),
    .lenBad   (lenBad)
  );

  assign rateCode = codeOut;

endmodule

// File: tb/fsrate_decoder_test.sv
module fsrate_decoder_test;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst, syncEn, longDelay;
  logic [1:0] rateCode;
  logic       rateValid, lenBad;

  int nChecks = 0;
  int nFails  = 0;
  int pushed   [0:255];
  int pushedCl [0:255];
  int nEv;
  int lastGoodM;

  fsrate_decoder uut (
    .clk(clk), .rst(rst), .syncEn(syncEn), .longDelay(longDelay),
    .rateCode(rateCode), .rateValid(rateValid), .lenBad(lenBad)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int classify(input int len);
    case (len)
      2: return 0;
      3: return 1;
      4: return 2;
      8: return 3;
      default: return -1;
    endcase
  endfunction

  task automatic doReset();
    rst = 1'b1;
    syncEn = 1'b0;
    repeat (3) @(negedge clk);
    // R6: outputs idle while in reset
    check("R6", int'(rateCode), 3);
    check("R6", int'(rateValid), 0);
    rst = 1'b0;
    nEv = 0;
    lastGoodM = 3;
    @(negedge clk);
    check("R6", int'(rateCode), 3);
    check("R6", int'(rateValid), 0);
    check("R6", int'(lenBad), 0);
  endtask

  task automatic frame(input int len, input int gap);
    int cls, d, src, expCode, expValid, expBad;
    string tagCode, tagBad;
    @(negedge clk);
    syncEn = 1'b1;
    repeat (len) @(negedge clk);
    syncEn = 1'b0;
    cls = classify(len);
    nEv++;
    if (cls >= 0) lastGoodM = cls;
    pushed[nEv]   = lastGoodM;
    pushedCl[nEv] = cls;
    d   = longDelay ? 6 : 2;
    src = nEv - d;
    expCode  = (src >= 1) ? pushed[src] : 3;
    expValid = (nEv > d) ? 1 : 0;
    expBad   = (cls < 0) ? 1 : 0;
    if (src >= 1 && pushedCl[src] < 0) tagCode = "R2";
    else                                tagCode = longDelay ? "R4" : "R3";
    if (cls >= 0)     tagBad = "R2";
    else if (len >= 15) tagBad = "R8";
    else              tagBad = "R2";
    // event edge is the next posedge; sample at the following negedge
    @(negedge clk);
    check(tagCode, int'(rateCode), expCode);
    check("R5", int'(rateValid), expValid);
    check(tagBad, int'(lenBad), expBad);
    if (src >= 1 && pushedCl[src] >= 0)
      check("R1", int'(rateCode), pushedCl[src]);
    @(negedge clk);
    // R5: strobe is one clock; R7: outputs hold in the gap
    check("R5", int'(rateValid), 0);
    check("R7", int'(rateCode), expCode);
    check("R7", int'(lenBad), expBad);
    repeat (gap) @(negedge clk);
    check("R7", int'(rateCode), expCode);
  endtask

  int lens [20] = '{2, 3, 4, 8, 1, 5, 3, 6, 7, 9, 2, 10, 11, 12, 8, 15, 16, 18, 19, 4};

  initial begin
    rst = 1'b1;
    syncEn = 1'b0;
    longDelay = 1'b0;
    // short tap, R3
    doReset();
    for (int i = 0; i < 20; i++) frame(lens[i], 2 + (i % 4));
    for (int i = 19; i >= 0; i--) frame(lens[i], 3);
    // long tap, R4
    longDelay = 1'b1;
    doReset();
    for (int i = 0; i < 20; i++) frame(lens[i], 2 + (i % 3));
    for (int l = 1; l <= 19; l++) frame(l, 2);
    // invalid straight after reset repeats code 3 (R2)
    longDelay = 1'b0;
    doReset();
    frame(5, 2);
    frame(6, 2);
    frame(3, 2);
    frame(1, 2);
    frame(18, 2);
    frame(2, 40);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    nFails++;
    $display("FAIL watchdog (R1..R8 run did not finish)");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule